// File: doc/BRIEF.md
# One-Time Fuse Array Controller

This block holds a 128-bit one-time-programmable fuse array and enforces the permission rules around it for a small authentication device. An upstream decoder hands it one command at a time: a 32-bit read, a burn of a single status fuse, a burn from an 88-bit map, or a pause-select used to park devices that share a wire. The block replies with a one-byte status and, for reads, a 32-bit data word. While a burn runs it raises a busy signal. The burn time is a programmed number of cycles per fuse, and the bulk burn takes that time once for every fuse it burns.

Each fuse starts at 1 and a burn clears it to 0. A cleared fuse can never be set again. Some fuses inside the array act as locks: one enables single burns, one locks the bulk burn, and four hold a device selector. A bulk map can be decrypted before use by XOR with a stored transport digest. The digest arrives on its own input with a load strobe and is cleared by a sleep or watchdog event.

Top module: `otp_fuse_ctrl`

## Requirements
- R1: After reset every fuse reads 1, and `busy`, `paused` and `rsp_valid` are 0.
- R2: A read (`cmd_op`=0) takes its address from `cmd_p2`. If address bit 1 is 1, the reply holds fuses 32*addr[1:0] upward, with the lowest-numbered fuse at `rsp_data[0]`. If address bit 1 is 0, the reply is ROM word addr[0]. Fuses 0 to 63 are never returned. The status is 0x00, and the reply arrives on the clock edge that accepts the command.
- R3: A read with any of address bits 2 to 15 set replies with status 0x0F and data 0.
- R4: A single burn (`cmd_op`=1) clears fuse `cmd_p1`. It is allowed only for fuse numbers 64 to 86 and only while fuse 1 reads 1. Any other case replies 0x0F at once and changes nothing.
- R5: The burn-time parameter `cmd_p2` selects BURN_FAST cycles per fuse when it is 0x0000 and BURN_SLOW when it is 0x8000. Any other value makes a burn reply 0x0F.
- R6: A bulk burn (`cmd_op`=2) clears fuse i for every map bit i that is 1 and leaves the other fuses unchanged. `busy` stays high for (number of 1 bits) × (cycles per fuse) cycles. The fuses change and status 0x00 is reported on the edge where `busy` falls. An empty map replies at once. If fuse 87 is already 0, the command replies 0x0F.
- R7: When `cmd_p1` bit 0 is 1, the bulk map is XORed bit by bit with the stored 88-bit digest before use. Without a digest loaded since the last sleep event, the command replies 0x0F. An accepted decrypting burn consumes the digest.
- R8: `sleep_evt` clears the stored digest and the pause state. It also aborts a running burn with no reply and no change to any fuse.
- R9: Pause-select (`cmd_op`=3) parks the device when the selector `cmd_p1` is 0x00, or when its low 4 bits equal fuses 87..84 (fuse 84 is the LSB). On a match the command gives no reply and sets `paused`. A mismatch replies 0x0F. While paused, every command is ignored.
- R10: A command that arrives while `busy` is high is ignored.
- R11: No fuse ever changes from 0 to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; sets every fuse to 1 |
| cmd_valid | input | 1 | Command strobe, one cycle |
| cmd_op | input | 2 | 0 read, 1 single burn, 2 bulk burn, 3 pause-select |
| cmd_p1 | input | 8 | Fuse number, decrypt flag (bit 0) or selector |
| cmd_p2 | input | 16 | Read address, or burn-time selector |
| cmd_map | input | 88 | Bulk burn map; bit i controls fuse i |
| dig_load | input | 1 | Stores `dig_in` as the transport digest |
| dig_in | input | 88 | First 88 bits of the transport digest |
| sleep_evt | input | 1 | Sleep or watchdog event |
| rsp_valid | output | 1 | Reply strobe, one cycle |
| rsp_status | output | 8 | 0x00 for success, 0x0F for an execution error |
| rsp_data | output | 32 | Read data; 0 for other replies |
| busy | output | 1 | A burn is in progress |
| paused | output | 1 | The device is parked by pause-select |

## Verification
Reads, rejected commands and empty bulk maps reply on the edge that accepts them. The bench drives each command on a falling edge and samples the reply on the next falling edge. A burn of C cycles keeps `busy` high through the C-1 falling edges that follow the command. Its reply and the fuse change appear together at falling edge C, and the bench checks `busy` and the reply at exactly those points. An effect that should be absent, such as an ignored command, an aborted burn or a pause, is checked on the cycle where a reply would otherwise fall due. The fuses are then read back to confirm that nothing changed.

// File: rtl/otp_pkg.sv
package otp_pkg;
  localparam int FUSE_N     = 128;
  localparam int MAP_W      = 88;
  localparam int WORD_W     = 32;
  localparam int IDX_W      = $clog2(FUSE_N);
  // fuse positions whose meaning the block decodes
  localparam int F_ONE_EN   = 1;
  localparam int F_STAT_LO  = 64;
  localparam int F_STAT_HI  = 86;
  localparam int F_SEL_LO   = 84;
  localparam int F_MAP_LOCK = 87;

  typedef enum logic [1:0] {
    OP_READ     = 2'd0,
    OP_BURN_ONE = 2'd1,
    OP_BURN_MAP = 2'd2,
    OP_PAUSE    = 2'd3
  } op_e;

  localparam logic [7:0] ST_OK  = 8'h00;
  localparam logic [7:0] ST_ERR = 8'h0F;

  function automatic int unsigned ones_in_map(input logic [MAP_W-1:0] m);
    int unsigned n = 0;
    for (int i = 0; i < MAP_W; i++) n += int'(m[i]);
    return n;
  endfunction
endpackage

// File: rtl/otp_fuse_array.sv
module otp_fuse_array import otp_pkg::*; (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr_en,
  input  logic [FUSE_N-1:0] clr_mask,
  output logic [FUSE_N-1:0] fuse_q
);
  // burning is modelled as a one-way clear of the selected bits
  always_ff @(posedge clk) begin
    if (rst)         fuse_q <= '1;
    else if (clr_en) fuse_q <= fuse_q & ~clr_mask;
  end
endmodule

// File: rtl/otp_burn_timer.sv
module otp_burn_timer #(
  parameter int CNT_W = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             abort,
  input  logic             start,
  input  logic [CNT_W-1:0] load,
  output logic             busy,
  output logic             done
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || abort) begin
      busy  <= 1'b0;
      cnt_q <= '0;
    end else if (start && load != '0) begin
      busy  <= 1'b1;
      cnt_q <= load;
    end else if (busy) begin
      if (cnt_q == CNT_W'(1)) busy <= 1'b0;
      cnt_q <= cnt_q - CNT_W'(1);
    end
  end

  assign done = busy && (cnt_q == CNT_W'(1));
endmodule

// File: rtl/otp_cmd_check.sv
module otp_cmd_check import otp_pkg::*; #(
  parameter int              CNT_W     = 10,
  parameter int              BURN_FAST = 3,
  parameter int              BURN_SLOW = 10,
  parameter logic [WORD_W-1:0] ROM_WORD0 = '0,
  parameter logic [WORD_W-1:0] ROM_WORD1 = '0
) (
  input  op_e               op,
  input  logic [7:0]        p1,
  input  logic [15:0]       p2,
  input  logic [MAP_W-1:0]  map,
  input  logic [FUSE_N-1:0] fuse,
  input  logic              dig_valid,
  input  logic [MAP_W-1:0]  dig,
  output logic              err,
  output logic [WORD_W-1:0] rd_data,
  output logic              pause_hit,
  output logic [FUSE_N-1:0] burn_mask,
  output logic [CNT_W-1:0]  burn_cycles,
  output logic              use_dig
);
  logic              time_ok;
  int unsigned       per_fuse;
  int unsigned       base;
  logic [MAP_W-1:0]  eff_map;

  always_comb begin
    time_ok     = (p2 == 16'h0000) || (p2 == 16'h8000);
    per_fuse    = p2[15] ? BURN_SLOW : BURN_FAST;
    base        = {p2[1:0], 5'b0};
    eff_map     = map ^ (p1[0] ? dig : '0);
    err         = 1'b0;
    rd_data     = '0;
    pause_hit   = 1'b0;
    burn_mask   = '0;
    burn_cycles = '0;
    use_dig     = 1'b0;
    unique case (op)
      OP_READ: begin
        err = |p2[15:2];
        if (!err) begin
          if (p2[1]) begin
            for (int b = 0; b < WORD_W; b++)
              if (base + b < FUSE_N) rd_data[b] = fuse[IDX_W'(base + b)];
          end else begin
            rd_data = p2[0] ? ROM_WORD1 : ROM_WORD0;
          end
        end
      end
      OP_BURN_ONE: begin
        err = !fuse[F_ONE_EN] || (p1 < 8'(F_STAT_LO)) || (p1 > 8'(F_STAT_HI)) || !time_ok;
        if (p1 < 8'(FUSE_N)) burn_mask[IDX_W'(p1)] = 1'b1;
        burn_cycles = CNT_W'(per_fuse);
      end
      OP_BURN_MAP: begin
        err = !fuse[F_MAP_LOCK] || (p1[0] && !dig_valid) || !time_ok;
        burn_mask   = FUSE_N'(eff_map);
        burn_cycles = CNT_W'(ones_in_map(eff_map) * per_fuse);
        use_dig     = p1[0];
      end
      OP_PAUSE: begin
        pause_hit = (p1 == 8'h00) || (p1[3:0] == fuse[F_MAP_LOCK:F_SEL_LO]);
        err       = !pause_hit;
      end
      default: err = 1'b1;
    endcase
  end
endmodule

// File: rtl/otp_fuse_ctrl.sv
module otp_fuse_ctrl import otp_pkg::*; #(
  parameter int                BURN_FAST = 3,
  parameter int                BURN_SLOW = 10,
  parameter logic [WORD_W-1:0] ROM_WORD0 = 32'h5A3C_0001,
  parameter logic [WORD_W-1:0] ROM_WORD1 = 32'h0000_0007
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_valid,
  input  logic [1:0]        cmd_op,
  input  logic [7:0]        cmd_p1,
  input  logic [15:0]       cmd_p2,
  input  logic [MAP_W-1:0]  cmd_map,
  input  logic              dig_load,
  input  logic [MAP_W-1:0]  dig_in,
  input  logic              sleep_evt,
  output logic              rsp_valid,
  output logic [7:0]        rsp_status,
  output logic [WORD_W-1:0] rsp_data,
  output logic              busy,
  output logic              paused
);
  localparam int CNT_W = $clog2(MAP_W * BURN_SLOW + 1);

  op_e               op;
  logic [FUSE_N-1:0] fuse_q;
  logic [FUSE_N-1:0] pend_mask_q;
  logic              paused_q;
  logic              dig_valid_q;
  logic [MAP_W-1:0]  dig_q;

  logic              c_err, c_pause, c_use_dig;
  logic [WORD_W-1:0] c_rd;
  logic [FUSE_N-1:0] c_mask;
  logic [CNT_W-1:0]  c_cycles;

  logic t_busy, t_done, accept, is_burn, start, fire;

  assign op      = op_e'(cmd_op);
  assign accept  = cmd_valid && !t_busy && !paused_q && !sleep_evt;   // R10, R9
  assign is_burn = (op == OP_BURN_ONE) || (op == OP_BURN_MAP);
  assign start   = accept && !c_err && is_burn && (c_cycles != '0);
  assign fire    = t_done && !sleep_evt;                             // R8

  otp_cmd_check #(
    .CNT_W(CNT_W), .BURN_FAST(BURN_FAST), .BURN_SLOW(BURN_SLOW),
    .ROM_WORD0(ROM_WORD0), .ROM_WORD1(ROM_WORD1)
  ) u_check (
    .op(op), .p1(cmd_p1), .p2(cmd_p2), .map(cmd_map), .fuse(fuse_q),
    .dig_valid(dig_valid_q), .dig(dig_q), .err(c_err), .rd_data(c_rd),
    .pause_hit(c_pause), .burn_mask(c_mask), .burn_cycles(c_cycles),
    .use_dig(c_use_dig)
  );

  otp_burn_timer #(.CNT_W(CNT_W)) u_timer (
    .clk(clk), .rst(rst), .abort(sleep_evt), .start(start),
    .load(c_cycles), .busy(t_busy), .done(t_done)
  );

  otp_fuse_array u_array (
    .clk(clk), .rst(rst), .clr_en(fire), .clr_mask(pend_mask_q), .fuse_q(fuse_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid   <= 1'b0;
      rsp_status  <= ST_OK;
      rsp_data    <= '0;
      paused_q    <= 1'b0;
      dig_valid_q <= 1'b0;
      dig_q       <= '0;
      pend_mask_q <= '0;
    end else begin
      rsp_valid <= 1'b0;
      if (sleep_evt) begin
        paused_q    <= 1'b0;
        dig_valid_q <= 1'b0;
      end else begin
        if (dig_load) begin
          dig_valid_q <= 1'b1;
          dig_q       <= dig_in;
        end
        if (accept) begin
          if (c_err) begin
            rsp_valid  <= 1'b1;
            rsp_status <= ST_ERR;
            rsp_data   <= '0;
          end else if (op == OP_READ) begin
            rsp_valid  <= 1'b1;
            rsp_status <= ST_OK;
            rsp_data   <= c_rd;
          end else if (op == OP_PAUSE) begin
            paused_q <= c_pause;
          end else begin
            pend_mask_q <= c_mask;
            if (c_use_dig) dig_valid_q <= 1'b0;   // R7 digest consumed
            if (c_cycles == '0) begin
              rsp_valid  <= 1'b1;
              rsp_status <= ST_OK;
              rsp_data   <= '0;
            end
          end
        end
        if (fire) begin
          rsp_valid  <= 1'b1;
          rsp_status <= ST_OK;
          rsp_data   <= '0;
        end
      end
    end
  end

  assign busy   = t_busy;
  assign paused = paused_q;
endmodule

// File: rtl/otp_fuse_ctrl_chk.sv
module otp_fuse_ctrl_chk import otp_pkg::*; (
  input logic              clk,
  input logic              rst,
  input logic              cmd_valid,
  input logic [1:0]        cmd_op,
  input logic              sleep_evt,
  input logic              rsp_valid,
  input logic [7:0]        rsp_status,
  input logic              busy,
  input logic              paused,
  input logic              dig_valid,
  input logic [FUSE_N-1:0] fuse
);
  assert_fuse_one_way_R11: assert property (@(posedge clk) disable iff (rst)
    (fuse & ~$past(fuse)) == '0);

  assert_read_replies_R2: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_op == 2'd0 && !busy && !paused && !sleep_evt) |=> rsp_valid);

  assert_status_codes_R3: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> (rsp_status == ST_OK || rsp_status == ST_ERR));

  assert_sleep_clears_R8: assert property (@(posedge clk) disable iff (rst)
    sleep_evt |=> (!busy && !paused && !rsp_valid && !dig_valid));

  assert_paused_silent_R9: assert property (@(posedge clk) disable iff (rst)
    paused |-> (!rsp_valid && !busy));

  assert_busy_ignores_R10: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy)) |-> !rsp_valid);
endmodule

bind otp_fuse_ctrl otp_fuse_ctrl_chk u_chk (
  .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
  .sleep_evt(sleep_evt), .rsp_valid(rsp_valid), .rsp_status(rsp_status),
  .busy(busy), .paused(paused), .dig_valid(dig_valid_q), .fuse(fuse_q)
);

// File: tb/otp_fuse_ctrl_tb.sv
module otp_fuse_ctrl_tb;
  localparam int FAST = 3;
  localparam int SLOW = 10;
  localparam logic [31:0] ROM0 = 32'h5A3C_0001;
  localparam logic [31:0] ROM1 = 32'h0000_0007;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cmd_valid = 1'b0;
  logic [1:0]  cmd_op = '0;
  logic [7:0]  cmd_p1 = '0;
  logic [15:0] cmd_p2 = '0;
  logic [87:0] cmd_map = '0;
  logic        dig_load = 1'b0;
  logic [87:0] dig_in = '0;
  logic        sleep_evt = 1'b0;
  logic        rsp_valid;
  logic [7:0]  rsp_status;
  logic [31:0] rsp_data;
  logic        busy, paused;

  int total = 0;
  int fails = 0;

  always #4 clk = ~clk;

  otp_fuse_ctrl #(.BURN_FAST(FAST), .BURN_SLOW(SLOW), .ROM_WORD0(ROM0), .ROM_WORD1(ROM1)) u_dut (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_p1(cmd_p1),
    .cmd_p2(cmd_p2), .cmd_map(cmd_map), .dig_load(dig_load), .dig_in(dig_in),
    .sleep_evt(sleep_evt), .rsp_valid(rsp_valid), .rsp_status(rsp_status),
    .rsp_data(rsp_data), .busy(busy), .paused(paused)
  );

  // {op, p1, p2, exp_valid, exp_status, exp_data}, applied from the reset state
  localparam int NV = 13;
  localparam logic [66:0] VEC [NV] = '{
    {2'd0, 8'h00, 16'h0002, 1'b1, 8'h00, 32'hFFFF_FFFF},  // R1 R2 fuses 64..95
    {2'd0, 8'h00, 16'h0003, 1'b1, 8'h00, 32'hFFFF_FFFF},  // R2 fuses 96..127
    {2'd0, 8'h00, 16'h0000, 1'b1, 8'h00, ROM0},           // R2 ROM word 0
    {2'd0, 8'h00, 16'h0001, 1'b1, 8'h00, ROM1},           // R2 ROM word 1
    {2'd0, 8'h00, 16'h0006, 1'b1, 8'h0F, 32'h0},          // R3 bit 2 set
    {2'd0, 8'h00, 16'h8002, 1'b1, 8'h0F, 32'h0},          // R3 bit 15 set
    {2'd1, 8'd63, 16'h0000, 1'b1, 8'h0F, 32'h0},          // R4 below status range
    {2'd1, 8'd87, 16'h0000, 1'b1, 8'h0F, 32'h0},          // R4 above status range
    {2'd1, 8'd70, 16'h1234, 1'b1, 8'h0F, 32'h0},          // R5 bad burn time
    {2'd2, 8'h01, 16'h0000, 1'b1, 8'h0F, 32'h0},          // R7 no digest loaded
    {2'd3, 8'h05, 16'h0000, 1'b1, 8'h0F, 32'h0},          // R9 selector mismatch
    {2'd2, 8'h00, 16'h4000, 1'b1, 8'h0F, 32'h0},          // R5 bad burn time, bulk
    {2'd2, 8'h00, 16'h0000, 1'b1, 8'h00, 32'h0}           // R6 empty map replies at once
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic issue(input logic [1:0] op, input logic [7:0] p1, input logic [15:0] p2,
                       input logic [87:0] map);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; cmd_p1 = p1; cmd_p2 = p2; cmd_map = map;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic read_chk(input string req, input logic [15:0] addr, input logic [31:0] exp);
    issue(2'd0, 8'h00, addr, '0);
    chk(req, {31'b0, rsp_valid}, 32'd1);
    chk(req, rsp_data, exp);
  endtask

  task automatic burn_wait(input string req, input int c);
    chk(req, {31'b0, busy}, 32'd1);
    repeat (c - 1) @(negedge clk);
    chk(req, {30'b0, busy, rsp_valid}, 32'd2);
    @(negedge clk);
    chk(req, {23'b0, rsp_valid, rsp_status}, {23'b0, 1'b1, 8'h00});
    chk(req, {31'b0, busy}, 32'd0);
  endtask

  task automatic err_chk(input string req);
    chk(req, {23'b0, rsp_valid, rsp_status}, {23'b0, 1'b1, 8'h0F});
  endtask

  task automatic pulse_sleep();
    @(negedge clk); sleep_evt = 1'b1;
    @(negedge clk); sleep_evt = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++; total++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state at the ports
    chk("R1", {29'b0, busy, paused, rsp_valid}, 32'd0);

    for (int v = 0; v < NV; v++) begin
      issue(VEC[v][66:65], VEC[v][64:57], VEC[v][56:41], '0);
      chk($sformatf("vector %0d", v), {23'b0, rsp_valid, rsp_status}, {23'b0, VEC[v][40:32]});
      chk($sformatf("vector %0d data", v), rsp_data, VEC[v][31:0]);
    end

    // R4: single burn of fuse 70, fast timing
    issue(2'd1, 8'd70, 16'h0000, '0);
    burn_wait("R4", FAST);
    read_chk("R4", 16'h0002, 32'hFFFF_FFBF);

    // R5: slow timing on fuse 72
    issue(2'd1, 8'd72, 16'h8000, '0);
    burn_wait("R5", SLOW);
    read_chk("R5", 16'h0002, 32'hFFFF_FEBF);

    // R10: read during a burn of fuse 65 is ignored
    issue(2'd1, 8'd65, 16'h0000, '0);
    cmd_valid = 1'b1; cmd_op = 2'd0; cmd_p2 = 16'h0002;
    @(negedge clk);
    cmd_valid = 1'b0;
    chk("R10", {30'b0, busy, rsp_valid}, 32'd2);
    @(negedge clk);
    chk("R10", {31'b0, rsp_valid}, 32'd0);
    @(negedge clk);
    chk("R10", {23'b0, rsp_valid, rsp_status}, {23'b0, 1'b1, 8'h00});
    read_chk("R10", 16'h0002, 32'hFFFF_FEBD);

    // R6: bulk burn of fuses 74 and 75 takes two fuse times
    issue(2'd2, 8'h00, 16'h0000, (88'd1 << 74) | (88'd1 << 75));
    burn_wait("R6", 2 * FAST);
    read_chk("R6", 16'h0002, 32'hFFFF_F2BD);

    // R7: digest bit 76 cancels map bit 76, only fuse 77 burns
    @(negedge clk); dig_load = 1'b1; dig_in = 88'd1 << 76;
    @(negedge clk); dig_load = 1'b0;
    issue(2'd2, 8'h01, 16'h0000, (88'd1 << 76) | (88'd1 << 77));
    burn_wait("R7", FAST);
    read_chk("R7", 16'h0002, 32'hFFFF_D2BD);
    issue(2'd2, 8'h01, 16'h0000, 88'd1 << 78);
    err_chk("R7 digest consumed");

    // R8: sleep clears a loaded digest
    @(negedge clk); dig_load = 1'b1;
    @(negedge clk); dig_load = 1'b0;
    pulse_sleep();
    issue(2'd2, 8'h01, 16'h0000, 88'd1 << 78);
    err_chk("R8 digest cleared");

    // R8: sleep aborts a slow burn of fuse 80
    issue(2'd1, 8'd80, 16'h8000, '0);
    @(negedge clk); sleep_evt = 1'b1;
    @(negedge clk); sleep_evt = 1'b0;
    chk("R8 abort", {31'b0, busy}, 32'd0);
    begin
      logic seen = 1'b0;
      for (int i = 0; i < SLOW + 2; i++) begin
        @(negedge clk);
        seen |= rsp_valid;
      end
      chk("R8 no reply", {31'b0, seen}, 32'd0);
    end
    read_chk("R8 fuse kept", 16'h0002, 32'hFFFF_D2BD);

    // R9: selector 0x1F matches unburned fuses 87..84 = 4'hF
    issue(2'd3, 8'h1F, 16'h0000, '0);
    chk("R9 match", {30'b0, paused, rsp_valid}, 32'd2);
    issue(2'd0, 8'h00, 16'h0002, '0);
    chk("R9 ignored", {31'b0, rsp_valid}, 32'd0);
    pulse_sleep();
    chk("R8 unpause", {31'b0, paused}, 32'd0);
    issue(2'd3, 8'h00, 16'h0000, '0);
    chk("R9 broadcast", {30'b0, paused, rsp_valid}, 32'd2);
    pulse_sleep();
    issue(2'd1, 8'd84, 16'h0000, '0);
    burn_wait("R9 burn 84", FAST);
    issue(2'd3, 8'h0F, 16'h0000, '0);
    err_chk("R9 mismatch");
    chk("R9 mismatch", {31'b0, paused}, 32'd0);
    issue(2'd3, 8'h0E, 16'h0000, '0);
    chk("R9 new match", {30'b0, paused, rsp_valid}, 32'd2);
    pulse_sleep();

    // R4: burning fuse 1 disables single burns
    issue(2'd2, 8'h00, 16'h0000, 88'd1 << 1);
    burn_wait("R4 enable fuse", FAST);
    issue(2'd1, 8'd66, 16'h0000, '0);
    err_chk("R4 disabled");

    // R6: burning fuse 87 locks the bulk burn
    issue(2'd2, 8'h00, 16'h0000, 88'd1 << 87);
    burn_wait("R6 lock", FAST);
    issue(2'd2, 8'h00, 16'h0000, 88'd1 << 90 >> 3);
    err_chk("R6 locked");
    read_chk("R11 final", 16'h0002, 32'hFF6F_D2BD);
    read_chk("R2 secret hidden", 16'h0000, ROM0);

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule